// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block listens to an I2C bus in the slave role and decides, for the first byte after every START or repeated START, whether that byte is aimed at this device. The byte comes in MSB first. Its upper seven bits are the address and its last bit is the direction (1 = read). When the address is accepted, the block pulls SDA low for the acknowledge clock. It also emits a one-cycle strobe that carries the address, the direction and a general-call flag, together with a wake-up pulse for a sleeping system.

Three match modes are available through a 2-bit mode field. The first compares one address through a don't-care mask. The second accepts either of two addresses. The third accepts an inclusive range. Address 0x00 is handled only as the general call, which can be turned on in any mode. Data bytes after the address phase, clock stretching and SCL generation are handled elsewhere. The SDA and SCL inputs are expected to be already synchronized and filtered.

Top module: `i2c_addr_matcher`

## Requirements
- R1: Each SCL rising edge after a START shifts one SDA bit in, MSB first. The eighth bit completes the byte. Byte bits [7:1] form the 7-bit address and bit 0 is the direction (1 = read). match_addr and match_rw report these values.
- R2: Address 0x00 is never matched by the own-address modes. When cfg_gc_en = 1, address 0x00 with direction write is accepted and match_gc = 1. A read to 0x00 is never acknowledged. For every other accepted address, match_gc = 0.
- R3: With cfg_mode = 00 (mask), a nonzero address is accepted when it equals cfg_addr in every bit position where cfg_aux holds 0.
- R4: With cfg_mode = 01 (dual), a nonzero address is accepted when it equals cfg_addr or cfg_aux.
- R5: With cfg_mode = 10 (range), a nonzero address is accepted when cfg_addr <= address <= cfg_aux, inclusive. If cfg_addr > cfg_aux, no address is accepted.
- R6: With cfg_mode = 11, no address is accepted except the general call.
- R7: On acceptance, sda_pull is 0 while SCL is high for the eighth bit. It goes to 1 after the following SCL falling edge and stays 1 through the high phase of the ninth clock. It returns to 0 after the ninth clock's falling edge.
- R8: Each acceptance raises match_stb for exactly one clock, with match_addr, match_rw and match_gc valid in that cycle. wake_stb pulses in the same cycle.
- R9: After a byte that is not accepted, sda_pull stays 0 and no strobe is raised. Later bytes are ignored until the next START.
- R10: A repeated START at any point abandons the byte in progress and restarts capture from bit 0. It also releases sda_pull.
- R11: A STOP (SDA rising while SCL is high) returns the block to idle. SCL clocks that arrive without a new START are then ignored.
- R12: While reset is active and right after it, sda_pull, match_stb and wake_stb are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_in | input | 1 | Synchronized, filtered SDA level |
| scl_in | input | 1 | Synchronized, filtered SCL level |
| cfg_mode | input | 2 | Match mode: 00 mask, 01 dual, 10 range, 11 none |
| cfg_addr | input | 7 | Own address / second-free address / lower bound |
| cfg_aux | input | 7 | Mask (1 = ignore bit) / second address / upper bound |
| cfg_gc_en | input | 1 | Accept general call (0x00, write) |
| sda_pull | output | 1 | Drive SDA low (open-drain enable) |
| match_stb | output | 1 | One-cycle accepted-address strobe |
| match_addr | output | 7 | Received address, valid with match_stb |
| match_rw | output | 1 | Received direction bit, valid with match_stb |
| match_gc | output | 1 | Accepted byte was a general call |
| wake_stb | output | 1 | Wake-up pulse on acceptance |

## Verification
The properties on mode and address assume that the configuration inputs hold steady from a START until the acknowledge ends, so that a strobe can be judged against the configuration present in the same cycle. They also assume that SDA changes only while SCL is low, except at START and STOP, and that SDA and SCL never change in the same clock. The stimulus changes configuration only between transactions, with the bus idle. It separates every SDA and SCL change by several clocks, and it shapes START and STOP only with SCL held high.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [1:0] {
        MODE_MASK  = 2'b00,
        MODE_DUAL  = 2'b01,
        MODE_RANGE = 2'b10,
        MODE_NONE  = 2'b11
    } am_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK_LOW,
        ST_ACK_HIGH
    } am_state_e;

endpackage

// File: rtl/i2c_am_bus_events.sv
module i2c_am_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_i,
    input  logic scl_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    typedef struct packed {
        logic [1:0] sda;
        logic [1:0] scl;
    } ev_regs_t;

    ev_regs_t ev_d, ev_q;

    always_comb begin
        ev_d     = ev_q;
        ev_d.sda = {ev_q.sda[0], sda_i};
        ev_d.scl = {ev_q.scl[0], scl_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '1;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign sda_s     = ev_q.sda[0];
    assign scl_rise  = ev_q.scl[0] & ~ev_q.scl[1];
    assign scl_fall  = ~ev_q.scl[0] & ev_q.scl[1];
    assign start_evt = ev_q.scl[0] & ev_q.scl[1] & ev_q.sda[1] & ~ev_q.sda[0];
    assign stop_evt  = ev_q.scl[0] & ev_q.scl[1] & ~ev_q.sda[1] & ev_q.sda[0];

endmodule

// File: rtl/i2c_am_compare.sv
module i2c_am_compare
    import i2c_am_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] own_a,
    input  logic [AW-1:0] own_b,
    input  logic          gc_en,
    input  logic [AW-1:0] rx_addr,
    input  logic          rx_rw,
    output logic          hit,
    output logic          gc_hit
);

    logic own_hit;
    logic is_zero;

    always_comb begin
        unique case (am_mode_e'(mode))
            MODE_MASK:  own_hit = (((rx_addr ^ own_a) & ~own_b) == '0);
            MODE_DUAL:  own_hit = (rx_addr == own_a) || (rx_addr == own_b);
            MODE_RANGE: own_hit = (rx_addr >= own_a) && (rx_addr <= own_b);
            default:    own_hit = 1'b0;
        endcase
    end

    assign is_zero = (rx_addr == '0);
    assign gc_hit  = is_zero & gc_en & ~rx_rw;
    assign hit     = is_zero ? gc_hit : own_hit;

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
    import i2c_am_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_in,
    input  logic          scl_in,
    input  logic [1:0]    cfg_mode,
    input  logic [AW-1:0] cfg_addr,
    input  logic [AW-1:0] cfg_aux,
    input  logic          cfg_gc_en,
    output logic          sda_pull,
    output logic          match_stb,
    output logic [AW-1:0] match_addr,
    output logic          match_rw,
    output logic          match_gc,
    output logic          wake_stb
);

    localparam int CNT_W = $clog2(AW + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(AW);

    typedef struct packed {
        am_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    sh;
        logic             stb;
        logic [AW-1:0]    addr;
        logic             rw;
        logic             gc;
    } regs_t;

    regs_t r_d, r_q;

    logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic hit, gc_hit;

    i2c_am_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_i     (sda_in),
        .scl_i     (scl_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    // The shift register holds the 7 address bits once the 8th bit arrives;
    // the live SDA sample is the direction bit.
    i2c_am_compare #(.AW(AW)) u_compare (
        .mode    (cfg_mode),
        .own_a   (cfg_addr),
        .own_b   (cfg_aux),
        .gc_en   (cfg_gc_en),
        .rx_addr (r_q.sh),
        .rx_rw   (sda_s),
        .hit     (hit),
        .gc_hit  (gc_hit)
    );

    always_comb begin
        r_d     = r_q;
        r_d.stb = 1'b0;
        if (start_evt) begin
            r_d.st  = ST_ADDR;
            r_d.cnt = '0;
            r_d.sh  = '0;
        end else if (stop_evt) begin
            r_d.st = ST_IDLE;
        end else begin
            unique case (r_q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        if (r_q.cnt == LAST_BIT) begin
                            if (hit) begin
                                r_d.st   = ST_ACK_WAIT;
                                r_d.stb  = 1'b1;
                                r_d.addr = r_q.sh;
                                r_d.rw   = sda_s;
                                r_d.gc   = gc_hit;
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end else begin
                            r_d.sh  = {r_q.sh[AW-2:0], sda_s};
                            r_d.cnt = r_q.cnt + CNT_W'(1);
                        end
                    end
                end
                ST_ACK_WAIT: if (scl_fall) r_d.st = ST_ACK_LOW;
                ST_ACK_LOW:  if (scl_rise) r_d.st = ST_ACK_HIGH;
                ST_ACK_HIGH: if (scl_fall) r_d.st = ST_IDLE;
                default:     r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pull   = (r_q.st == ST_ACK_LOW) || (r_q.st == ST_ACK_HIGH);
    assign match_stb  = r_q.stb;
    assign wake_stb   = r_q.stb;
    assign match_addr = r_q.addr;
    assign match_rw   = r_q.rw;
    assign match_gc   = r_q.gc;

    p_stb_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_stb |=> !match_stb);

    p_gc_write_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (match_stb && match_gc) |-> (match_addr == '0 && !match_rw));

    p_zero_only_gc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (match_stb && !match_gc) |-> (match_addr != '0));

    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_stb && !match_gc && cfg_mode == 2'b00)
            |-> (((match_addr ^ cfg_addr) & ~cfg_aux) == '0));

    p_dual_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_stb && !match_gc && cfg_mode == 2'b01)
            |-> (match_addr == cfg_addr || match_addr == cfg_aux));

    p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match_stb && !match_gc && cfg_mode == 2'b10)
            |-> (match_addr >= cfg_addr && match_addr <= cfg_aux));

    p_none_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        match_stb |-> (match_gc || cfg_mode != 2'b11));

    p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_pull);

    p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_pull);

    p_pull_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_in);

endmodule

// File: tb/tb_i2c_addr_matcher.sv
module tb_i2c_addr_matcher;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sda_drv = 1'b1;
    logic scl_drv = 1'b1;
    logic [1:0] cfg_mode = 2'b00;
    logic [6:0] cfg_addr = 7'h00;
    logic [6:0] cfg_aux = 7'h00;
    logic cfg_gc_en = 1'b0;
    logic sda_pull, match_stb, match_rw, match_gc, wake_stb;
    logic [6:0] match_addr;
    logic sda_line;

    int n_tests = 0;
    int n_fail = 0;
    int stb_cnt = 0;
    int wake_cnt = 0;
    logic [6:0] l_addr = '0;
    logic l_rw = 1'b0;
    logic l_gc = 1'b0;
    logic early_pull = 1'b0;
    logic ack_seen = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_drv & ~sda_pull;

    i2c_addr_matcher dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_in     (sda_line),
        .scl_in     (scl_drv),
        .cfg_mode   (cfg_mode),
        .cfg_addr   (cfg_addr),
        .cfg_aux    (cfg_aux),
        .cfg_gc_en  (cfg_gc_en),
        .sda_pull   (sda_pull),
        .match_stb  (match_stb),
        .match_addr (match_addr),
        .match_rw   (match_rw),
        .match_gc   (match_gc),
        .wake_stb   (wake_stb)
    );

    always @(negedge clk) begin
        if (match_stb) begin
            stb_cnt++;
            l_addr = match_addr;
            l_rw   = match_rw;
            l_gc   = match_gc;
        end
        if (wake_stb) wake_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wq(Q);
        scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b0; wq(Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq(Q);
        scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b1; wq(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_drv = b[i]; wq(Q);
            scl_drv = 1'b1; wq(Q);
            scl_drv = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wq(Q);
            scl_drv = 1'b1; wq(Q / 2);
            if (i == 0) early_pull = sda_pull;
            wq(Q / 2);
            scl_drv = 1'b0;
        end
        sda_drv = 1'b1; wq(Q);
        scl_drv = 1'b1; wq(Q / 2);
        ack_seen = !sda_line;
        wq(Q / 2);
        scl_drv = 1'b0; wq(Q);
        chk(!sda_pull, "R7", "sda_pull released after ninth clock", int'(sda_pull), 0);
    endtask

    function automatic bit exp_gc(input logic [6:0] x, input logic r, input logic g);
        return (x == 7'h00) && g && !r;
    endfunction

    function automatic bit exp_hit(input logic [1:0] m, input logic [6:0] a,
                                   input logic [6:0] b, input logic g,
                                   input logic [6:0] x, input logic r);
        if (x == 7'h00) return exp_gc(x, r, g);
        case (m)
            2'b00: begin
                for (int k = 0; k < 7; k++)
                    if (!b[k] && (x[k] != a[k])) return 1'b0;
                return 1'b1;
            end
            2'b01: return (x == a) || (x == b);
            2'b10: return (int'(x) >= int'(a)) && (int'(x) <= int'(b));
            default: return 1'b0;
        endcase
    endfunction

    function automatic string mode_req(input logic [1:0] m, input logic [6:0] x);
        if (x == 7'h00) return "R2";
        case (m)
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic xact(input logic [6:0] x, input logic r);
        int s0, w0;
        bit eh, eg;
        string rq;
        s0 = stb_cnt;
        w0 = wake_cnt;
        eh = exp_hit(cfg_mode, cfg_addr, cfg_aux, cfg_gc_en, x, r);
        eg = exp_gc(x, r, cfg_gc_en);
        rq = mode_req(cfg_mode, x);
        bus_start();
        send_byte({x, r});
        chk(ack_seen == eh, rq, "acknowledge", int'(ack_seen), int'(eh));
        chk(stb_cnt - s0 == int'(eh), "R8", "match strobes", stb_cnt - s0, int'(eh));
        chk(wake_cnt - w0 == int'(eh), "R8", "wake pulses", wake_cnt - w0, int'(eh));
        chk(!early_pull, "R7", "no pull during eighth bit", int'(early_pull), 0);
        if (eh) begin
            chk(l_addr == x, "R1", "captured address", int'(l_addr), int'(x));
            chk(l_rw == r, "R1", "captured direction", int'(l_rw), int'(r));
            chk(l_gc == eg, "R2", "general call flag", int'(l_gc), int'(eg));
        end
        bus_stop();
        chk(!sda_pull, "R11", "idle after stop", int'(sda_pull), 0);
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [6:0] a,
                           input logic [6:0] b, input logic g);
        cfg_mode = m; cfg_addr = a; cfg_aux = b; cfg_gc_en = g;
        wq(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int s0;
        void'($urandom(32'h5eed_1234));
        wq(3);
        chk(!sda_pull && !match_stb && !wake_stb, "R12", "outputs in reset",
            int'({sda_pull, match_stb, wake_stb}), 0);
        rst_n = 1'b1;
        wq(3);
        chk(!sda_pull && !match_stb && !wake_stb, "R12", "outputs after reset",
            int'({sda_pull, match_stb, wake_stb}), 0);

        // R3 mask mode
        set_cfg(2'b00, 7'h2A, 7'h03, 1'b0);
        xact(7'h29, 1'b0);
        xact(7'h2B, 1'b1);
        xact(7'h2E, 1'b0);
        // R4 dual mode
        set_cfg(2'b01, 7'h10, 7'h77, 1'b0);
        xact(7'h10, 1'b1);
        xact(7'h77, 1'b0);
        xact(7'h11, 1'b0);
        // R5 range bounds
        set_cfg(2'b10, 7'h20, 7'h30, 1'b0);
        xact(7'h1F, 1'b0);
        xact(7'h20, 1'b0);
        xact(7'h30, 1'b1);
        xact(7'h31, 1'b0);
        set_cfg(2'b10, 7'h30, 7'h20, 1'b0);
        xact(7'h28, 1'b0);
        // R6 reserved mode
        set_cfg(2'b11, 7'h42, 7'h42, 1'b1);
        xact(7'h42, 1'b0);
        xact(7'h00, 1'b0);
        // R2 general call
        set_cfg(2'b00, 7'h00, 7'h7F, 1'b1);
        xact(7'h00, 1'b0);
        xact(7'h00, 1'b1);
        set_cfg(2'b00, 7'h00, 7'h7F, 1'b0);
        xact(7'h00, 1'b0);

        // R9: unmatched byte, then a matching byte without START
        set_cfg(2'b00, 7'h2A, 7'h00, 1'b0);
        s0 = stb_cnt;
        bus_start();
        send_byte({7'h11, 1'b0});
        chk(!ack_seen, "R9", "no ack on mismatch", int'(ack_seen), 0);
        send_byte({7'h2A, 1'b0});
        chk(!ack_seen, "R9", "later byte ignored", int'(ack_seen), 0);
        chk(stb_cnt == s0, "R9", "no strobe", stb_cnt - s0, 0);
        bus_stop();

        // R10: repeated START mid-byte
        s0 = stb_cnt;
        bus_start();
        send_bits(8'hFF, 4);
        bus_start();
        send_byte({7'h2A, 1'b1});
        chk(ack_seen, "R10", "ack after repeated start", int'(ack_seen), 1);
        chk(stb_cnt - s0 == 1, "R10", "one strobe", stb_cnt - s0, 1);
        chk(l_addr == 7'h2A && l_rw, "R10", "address after restart", int'({l_addr, l_rw}), int'({7'h2A, 1'b1}));
        // repeated START right after an acknowledged byte
        bus_start();
        send_byte({7'h2A, 1'b0});
        chk(ack_seen, "R10", "ack on second repeated start", int'(ack_seen), 1);
        bus_stop();

        // R11: STOP mid-byte, then clocks without START
        s0 = stb_cnt;
        bus_start();
        send_bits({7'h2A, 1'b0}, 4);
        bus_stop();
        scl_drv = 1'b0; wq(Q);
        send_byte({7'h2A, 1'b0});
        chk(!ack_seen, "R11", "no ack after stop", int'(ack_seen), 0);
        chk(stb_cnt == s0, "R11", "no strobe after stop", stb_cnt - s0, 0);
        scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b1; wq(Q);

        // constrained random
        for (int it = 0; it < 240; it++) begin
            logic [6:0] x;
            logic r;
            int sel;
            if (it % 8 == 0) begin
                logic [6:0] a, b;
                a = 7'($urandom);
                b = 7'($urandom);
                if (($urandom % 2) == 1 && a > b) begin
                    logic [6:0] t;
                    t = a; a = b; b = t;
                end
                set_cfg(2'($urandom), a, b, 1'($urandom));
            end
            sel = int'($urandom % 6);
            case (sel)
                0: x = cfg_addr;
                1: x = cfg_aux;
                2: x = 7'h00;
                3: x = cfg_addr ^ (7'h01 << ($urandom % 7));
                4: x = cfg_aux + 7'h01;
                default: x = 7'($urandom);
            endcase
            r = 1'($urandom);
            xact(x, r);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule